// File: doc/BRIEF.md
# Transparent Translation Range Matcher

This block sits beside a paged address translator and decides, for each access, whether the access bypasses page translation. It holds four window registers. Two serve data accesses and two serve instruction fetches. Each register describes a window in the top byte of the logical address, given as a base with a per-bit don't-care mask. It also carries an enable, a privilege selector and the attributes to apply on a hit: cache mode, write protect and two user page attribute bits.

An access presents its address, its kind (instruction or data), its privilege (supervisor or user) and whether it is a write. One clock later the block reports a hit flag together with the attributes of the winning window, or zeros on a miss. It raises a protection fault when a write lands in a write-protected window, and that write does not complete. A transparent-hit status flag records the outcome of the latest access and holds between accesses. Windows are loaded through a simple write port. The port selects one of the four registers, with indices 0 and 1 for data and 2 and 3 for instruction.

Top module: `tt_xlat_match`

## Requirements
- R1: After reset every window register is cleared and therefore disabled. `res_valid`, `res_hit`, the attribute outputs, `res_fault` and `stat_thit` are all 0.
- R2: A window matches an address only when every bit of `acc_addr[31:24]` equals the base in register bits 31:24, except where the mask in bits 23:16 holds a 1, which makes that bit a don't-care. Address bits 23:0 play no part in the match.
- R3: Register bit 15 enables the window. A window with bit 15 at 0 never hits, whatever its other fields hold.
- R4: The privilege selector in bits 14:13 admits user accesses only when it is 00, supervisor accesses only when it is 01, and both when it is 10. The value 11 never matches.
- R5: A data access (`acc_instr`=0) is compared only against registers 0 and 1. An instruction access (`acc_instr`=1) is compared only against registers 2 and 3.
- R6: On a hit, `res_cmode` takes register bits 6:5 (00 write-through, 01 copy-back, 10 non-cacheable serialized, 11 non-cacheable), `res_wprot` takes bit 2, and `res_upa` takes bits 9:8. On a miss all three are 0.
- R7: When both registers of the checked set match, the lower-numbered register supplies the attributes.
- R8: `res_fault` is 1 exactly when the access is a write, it hits, and the winning window has write protect set. Reads and misses never fault.
- R9: `stat_thit` takes the hit outcome of each valid access and keeps its value while `acc_valid` is 0.
- R10: Results appear on the clock edge after the access is sampled. `res_valid` follows `acc_valid` with one cycle of delay, and without a valid access `res_hit` and `res_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a window register |
| cfg_sel | input | 2 | Register index: 0,1 data; 2,3 instruction |
| cfg_wdata | input | 32 | Register value to store |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Logical address of the access |
| acc_instr | input | 1 | 1 for instruction fetch, 0 for data |
| acc_super | input | 1 | 1 for supervisor, 0 for user |
| acc_write | input | 1 | 1 for a write access |
| res_valid | output | 1 | Result for the previous cycle's access |
| res_hit | output | 1 | Transparent window hit |
| res_cmode | output | 2 | Cache mode of the winning window |
| res_wprot | output | 1 | Write protect of the winning window |
| res_upa | output | 2 | User page attributes of the winning window |
| res_fault | output | 1 | Write to a protected window |
| stat_thit | output | 1 | Status flag: last access hit a window |

## Verification
The window set is loaded with overlapping regions. Accesses then test the base compare against mask bits on both the high and the low nibble, and they vary the access privilege across windows that admit user only, supervisor only, both, or neither. Addresses that hit both data windows show which register wins. The same address issued as data and as instruction shows that the set is chosen by access kind. The same address issued as a read and as a write separates a plain hit from a protection fault. Directed steps then toggle the enable of one window, and idle cycles between accesses show that the status flag holds its value while the result outputs drop to zero.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
    localparam int CFG_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int BASE_LSB = 24;
    localparam int MASK_LSB = 16;
    localparam int EN_BIT   = 15;
    localparam int PRIV_LSB = 13;
    localparam int UPA_LSB  = 8;
    localparam int CM_LSB   = 5;
    localparam int WP_BIT   = 2;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_ANY   = 2'b10,
        PRIV_NONE  = 2'b11
    } priv_e;

    typedef struct packed {
        logic [1:0] upa;
        logic [1:0] cmode;
        logic       wprot;
    } attr_t;

    function automatic logic priv_ok(priv_e sel, logic is_super);
        case (sel)
            PRIV_USER:  return !is_super;
            PRIV_SUPER: return is_super;
            PRIV_ANY:   return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/ttm_entry.sv
module ttm_entry
    import ttm_pkg::*;
(
    input  logic [CFG_W-1:0]  win_word,
    input  logic [BYTE_W-1:0] addr_hi,
    input  logic              is_super,
    output logic              hit,
    output attr_t             attr
);
    logic [BYTE_W-1:0] base_b;
    logic [BYTE_W-1:0] mask_b;
    logic [BYTE_W-1:0] diff_b;
    priv_e             sel_p;

    always_comb begin
        base_b     = win_word[BASE_LSB +: BYTE_W];
        mask_b     = win_word[MASK_LSB +: BYTE_W];
        sel_p      = priv_e'(win_word[PRIV_LSB +: 2]);
        diff_b     = (addr_hi ^ base_b) & ~mask_b;
        hit        = win_word[EN_BIT] && (diff_b == '0) && priv_ok(sel_p, is_super);
        attr.upa   = win_word[UPA_LSB +: 2];
        attr.cmode = win_word[CM_LSB +: 2];
        attr.wprot = win_word[WP_BIT];
    end
endmodule

// File: rtl/ttm_pick.sv
module ttm_pick
    import ttm_pkg::*;
#(
    parameter int PER_SET = 2,
    localparam int NWIN   = 2 * PER_SET
) (
    input  logic [NWIN-1:0] ent_hit,
    input  attr_t [NWIN-1:0] ent_attr,
    input  logic            use_instr,
    output logic            hit,
    output attr_t           attr
);
    always_comb begin
        hit  = 1'b0;
        attr = '0;
        for (int k = PER_SET - 1; k >= 0; k--) begin
            if (ent_hit[use_instr ? PER_SET + k : k]) begin
                hit  = 1'b1;
                attr = ent_attr[use_instr ? PER_SET + k : k];
            end
        end
    end
endmodule

// File: rtl/tt_xlat_match.sv
module tt_xlat_match
    import ttm_pkg::*;
#(
    parameter int PER_SET = 2,
    parameter int ADDR_W  = 32,
    localparam int NWIN   = 2 * PER_SET,
    localparam int SEL_W  = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_instr,
    input  logic              acc_super,
    input  logic              acc_write,
    output logic              res_valid,
    output logic              res_hit,
    output logic [1:0]        res_cmode,
    output logic              res_wprot,
    output logic [1:0]        res_upa,
    output logic              res_fault,
    output logic              stat_thit
);
    typedef struct packed {
        logic [NWIN-1:0][CFG_W-1:0] win;
        logic                       vld;
        logic                       hit;
        attr_t                      attr;
        logic                       fault;
        logic                       thit;
    } state_t;

    state_t st_d, st_q;

    logic [NWIN-1:0]  ent_hit;
    attr_t [NWIN-1:0] ent_attr;
    logic             pick_hit;
    attr_t            pick_attr;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        ttm_entry u_ent (
            .win_word (st_q.win[g]),
            .addr_hi  (acc_addr[ADDR_W-1 -: BYTE_W]),
            .is_super (acc_super),
            .hit      (ent_hit[g]),
            .attr     (ent_attr[g])
        );
    end

    ttm_pick #(.PER_SET(PER_SET)) u_pick (
        .ent_hit   (ent_hit),
        .ent_attr  (ent_attr),
        .use_instr (acc_instr),
        .hit       (pick_hit),
        .attr      (pick_attr)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.win[cfg_sel] = cfg_wdata;
        end
        st_d.vld   = acc_valid;
        st_d.hit   = acc_valid && pick_hit;
        st_d.attr  = (acc_valid && pick_hit) ? pick_attr : '0;
        st_d.fault = acc_valid && pick_hit && acc_write && pick_attr.wprot;
        if (acc_valid) begin
            st_d.thit = pick_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.vld;
    assign res_hit   = st_q.hit;
    assign res_cmode = st_q.attr.cmode;
    assign res_wprot = st_q.attr.wprot;
    assign res_upa   = st_q.attr.upa;
    assign res_fault = st_q.fault;
    assign stat_thit = st_q.thit;
endmodule

// File: rtl/tt_xlat_match_chk.sv
module tt_xlat_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       res_valid,
    input logic       res_hit,
    input logic [1:0] res_cmode,
    input logic       res_wprot,
    input logic [1:0] res_upa,
    input logic       res_fault,
    input logic       stat_thit
);
    p_fault_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> (res_hit && res_wprot));

    p_miss_zero_attr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_cmode == 2'b00 && !res_wprot && res_upa == 2'b00));

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!res_valid && !res_hit && !res_fault));

    p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(stat_thit));

    p_status_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (stat_thit == res_hit));
endmodule

bind tt_xlat_match tt_xlat_match_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_cmode (res_cmode),
    .res_wprot (res_wprot),
    .res_upa   (res_upa),
    .res_fault (res_fault),
    .stat_thit (stat_thit)
);

// File: tb/tt_xlat_match_tb_top.sv
`timescale 1ns/1ps
module tt_xlat_match_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_instr = 1'b0;
    logic        acc_super = 1'b0;
    logic        acc_write = 1'b0;
    logic        res_valid, res_hit, res_wprot, res_fault, stat_thit;
    logic [1:0]  res_cmode, res_upa;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tt_xlat_match dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_instr(acc_instr), .acc_super(acc_super), .acc_write(acc_write),
        .res_valid(res_valid), .res_hit(res_hit), .res_cmode(res_cmode),
        .res_wprot(res_wprot), .res_upa(res_upa), .res_fault(res_fault),
        .stat_thit(stat_thit)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        instr;
        logic        sup;
        logic        wr;
        logic        hit;
        logic [1:0]  cm;
        logic        wp;
        logic [1:0]  upa;
        logic        flt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{32'h4A123456, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 2'b10, 1'b0}, // R2 R6 low-nibble don't-care
        '{32'h4A123456, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 1'b1, 2'b10, 1'b1}, // R8 write to protected
        '{32'h40000000, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 2'b10, 1'b0}, // R7 both data windows hit
        '{32'h50FFFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 2'b01, 1'b0}, // R4 supervisor-only admits
        '{32'h50FFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}, // R4 supervisor-only rejects user
        '{32'h50000000, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 2'b01, 1'b0}, // R8 write, unprotected
        '{32'h30000000, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 2'b01, 1'b0}, // R2 high-nibble don't-care
        '{32'h31000000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}, // R2 cared bit differs
        '{32'h80ABCDEF, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 2'b11, 1'b0}, // R5 R4 instr user-only
        '{32'h80ABCDEF, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}, // R4 user-only and never
        '{32'h4A000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}, // R5 data windows unused
        '{32'h80000000, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}, // R5 instr windows unused
        '{32'h81000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0}  // R2 zero mask exact
    };

    function automatic string tag_of(int i);
        case (i)
            0, 6, 7, 12: return "R2";
            1, 5:        return "R8";
            2:           return "R7";
            3, 4, 9:     return "R4";
            default:     return "R5";
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_win(logic [1:0] sel, logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(logic [31:0] a, logic i, logic s, logic w);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_instr = i; acc_super = s; acc_write = w;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    function automatic logic [6:0] outs();
        return {res_hit, res_cmode, res_wprot, res_upa, res_fault};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({res_valid, outs(), stat_thit} == '0, "R1",
              {23'd0, res_valid, outs(), stat_thit}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        access(32'h00000000, 1'b0, 1'b1, 1'b0);
        check(!res_hit && res_valid, "R1", {30'd0, res_valid, res_hit}, 32'd2);

        wr_win(2'd0, 32'h400FC224);
        wr_win(2'd1, 32'h40F0A160);
        wr_win(2'd2, 32'h80008340);
        wr_win(2'd3, 32'h8000E004);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].addr, VEC[i].instr, VEC[i].sup, VEC[i].wr);
            check(res_valid && outs() == {VEC[i].hit, VEC[i].cm, VEC[i].wp, VEC[i].upa, VEC[i].flt},
                  tag_of(i), {25'd0, outs()},
                  {25'd0, VEC[i].hit, VEC[i].cm, VEC[i].wp, VEC[i].upa, VEC[i].flt});
        end

        // R3: disabled window with all-admitting privilege never hits
        wr_win(2'd3, 32'h90004000);
        access(32'h90000000, 1'b1, 1'b1, 1'b0);
        check(!res_hit, "R3", {31'd0, res_hit}, 32'd0);
        wr_win(2'd3, 32'h9000C004);
        access(32'h90000000, 1'b1, 1'b1, 1'b0);
        check(res_hit && res_wprot && res_cmode == 2'b00, "R3",
              {28'd0, res_hit, res_cmode, res_wprot}, 32'h9);

        // R9 R10: status holds across idle cycles, results drop
        @(negedge clk);
        check(!res_valid && !res_hit && !res_fault, "R10",
              {29'd0, res_valid, res_hit, res_fault}, 32'd0);
        check(stat_thit == 1'b1, "R9", {31'd0, stat_thit}, 32'd1);
        repeat (3) @(negedge clk);
        check(stat_thit == 1'b1, "R9", {31'd0, stat_thit}, 32'd1);
        access(32'hF0000000, 1'b1, 1'b1, 1'b0);
        check(stat_thit == 1'b0 && res_valid, "R9", {30'd0, res_valid, stat_thit}, 32'd2);
        @(negedge clk);
        check(stat_thit == 1'b0, "R9", {31'd0, stat_thit}, 32'd0);

        // R1: reset clears windows again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(32'h4A000000, 1'b0, 1'b0, 1'b0);
        check(!res_hit && !stat_thit, "R1", {30'd0, res_hit, stat_thit}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule